// File: doc/BRIEF.md
# Three-Phase Sample-Hold and ADC Sequencer

This block runs the acquisition timing for one phase of a three-phase voltage and current front end each time it receives a sampling trigger. A trigger opens a frame. The block first lets the phase's paired voltage and current holders track the input. It then freezes both holders together, so that both quantities are captured at the same instant. While the holders are frozen, it points the analog multiplexer at the held voltage and runs one conversion. Later in the same hold window it points the multiplexer at the held current and runs a second conversion.

Each conversion follows the same handshake with a 12-bit converter that has an 8-bit data bus. The block lowers chip-select and read, and then waits for the busy line to rise. It reads the top four bits with byte-select high and then the low eight bits with byte-select low. After that it issues a one-cycle result strobe. The strobe carries the 12-bit code, the phase number and a voltage/current flag. If busy never rises, a watchdog abandons that conversion. Successive frames move through phases A, B and C and then wrap around.

All offsets come from a clock-cycle counter. With the default of 50 cycles per microsecond the frame lasts 70 µs: 10 µs of tracking followed by 60 µs of hold.

Top module: `sh_adc_sequencer`

## Requirements
- R1: After reset all hold lines are low, chip-select, read and byte-select are inactive (chip-select and read high, byte-select low), no strobe or timeout is raised, and the multiplexer address is parked at 3'b111.
- R2: A trigger seen while idle starts a frame. The selected phase's hold line stays low for TRACK_US microseconds, counted from the first cycle after the trigger is sampled. It then stays high for exactly HOLD_US microseconds. At most one hold line is high at any time, bit 0 = phase A, bit 1 = B, bit 2 = C.
- R3: The multiplexer address becomes {phase,1'b0} (voltage) exactly 1 µs after the hold line rises, and {phase,1'b1} (current) exactly 31 µs after it rises. Phase codes are A=0, B=1, C=2. The address does not change while chip-select is low.
- R4: Conversions start, with chip-select and read both driven low, exactly 2 µs and 32 µs after the hold line rises.
- R5: End of conversion is a low-to-high transition of busy. On it the block holds byte-select high for one cycle and takes data bits [3:0] as result bits [11:8]. It then holds byte-select low for one cycle and takes data bits [7:0] as result bits [7:0]. Chip-select and read are then released.
- R6: Each completed conversion gives one single-cycle result strobe. The strobe carries the 12-bit code, the phase code and a flag that is 1 for current and 0 for voltage.
- R7: If busy has not risen within 15 µs of a conversion start, the block raises a one-cycle timeout exactly 15 µs after the start and releases chip-select. That conversion produces no result strobe.
- R8: Successive frames use phases A, B, C, A, ... in order.
- R9: A trigger that arrives while a frame is in progress has no effect on that frame's timing and does not start an extra frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock (50 cycles per µs by default) |
| rst_n | input | 1 | Active-low synchronous reset |
| sample_go | input | 1 | Sampling trigger, one cycle |
| adc_busy | input | 1 | Converter status, rising edge = conversion done |
| adc_data | input | 8 | Converter data bus |
| hold | output | 3 | Per-phase hold control, 1 = hold, 0 = track |
| mux_addr | output | 3 | Multiplexer channel select {phase, current} |
| adc_cs_n | output | 1 | Converter chip-select, active low |
| adc_rd_n | output | 1 | Converter read/start, active low |
| adc_hbyte | output | 1 | Byte-select, 1 = upper nibble, 0 = lower byte |
| res_valid | output | 1 | Result strobe |
| res_data | output | 12 | Conversion code |
| res_phase | output | 2 | Phase code of the result |
| res_current | output | 1 | 1 = current sample, 0 = voltage sample |
| conv_timeout | output | 1 | One-cycle flag for an abandoned conversion |

## Verification
The hardest case to reach from the ports is the converter that never finishes. Normal stimulus always completes a conversion well inside its window, so the timeout path never runs. The bench's converter model therefore has a per-channel stuck switch that keeps busy low for the whole conversion. One frame uses it to stall the voltage conversion and another to stall the current conversion. Another frame finishes a conversion just short of the limit. The bench then checks when the timeout appears, that no strobe is produced, and that the conversion that follows is unaffected.

// File: rtl/sh_adc_sequencer.sv
module sh_adc_sequencer #(
  parameter int CYC_PER_US = 50,
  parameter int TRACK_US   = 10,
  parameter int HOLD_US    = 60,
  parameter int MUXV_US    = 1,
  parameter int STARTV_US  = 2,
  parameter int SECOND_US  = 30,
  parameter int TIMEOUT_US = 15
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        sample_go,
  input  logic        adc_busy,
  input  logic [7:0]  adc_data,
  output logic [2:0]  hold,
  output logic [2:0]  mux_addr,
  output logic        adc_cs_n,
  output logic        adc_rd_n,
  output logic        adc_hbyte,
  output logic        res_valid,
  output logic [11:0] res_data,
  output logic [1:0]  res_phase,
  output logic        res_current,
  output logic        conv_timeout
);
  localparam int TRK = TRACK_US * CYC_PER_US;
  localparam int FRM = TRK + HOLD_US * CYC_PER_US;
  localparam int TO  = TIMEOUT_US * CYC_PER_US;
  localparam int TW  = $clog2(FRM + 1);
  localparam int CW  = $clog2(TO + 1);
  localparam logic [TW-1:0] T_TRK  = TW'(TRK);
  localparam logic [TW-1:0] T_LAST = TW'(FRM - 1);
  localparam logic [TW-1:0] T_MV   = TW'(TRK + MUXV_US * CYC_PER_US - 1);
  localparam logic [TW-1:0] T_SV   = TW'(TRK + STARTV_US * CYC_PER_US - 1);
  localparam logic [TW-1:0] T_MI   = TW'(TRK + (MUXV_US + SECOND_US) * CYC_PER_US - 1);
  localparam logic [TW-1:0] T_SI   = TW'(TRK + (STARTV_US + SECOND_US) * CYC_PER_US - 1);
  localparam logic [CW-1:0] T_TO   = CW'(TO - 1);

  typedef enum logic [1:0] {C_IDLE, C_CONV, C_RDHI, C_RDLO} cst_t;

  logic          active;
  logic [TW-1:0] tick;
  logic [1:0]    phase;
  logic [CW-1:0] tcnt;
  cst_t          cst;
  logic          busy_q;
  logic [3:0]    hi_q;
  logic          cur_q;

  wire eoc     = adc_busy & ~busy_q;
  wire in_hold = active && (tick >= T_TRK);

  genvar p;
  generate
    for (p = 0; p < 3; p++) begin : g_hold
      assign hold[p] = in_hold && (phase == 2'(p));
    end
  endgenerate

  assign adc_cs_n  = (cst == C_IDLE);
  assign adc_rd_n  = (cst == C_IDLE);
  assign adc_hbyte = (cst == C_RDHI);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active   <= 1'b0;
      tick     <= '0;
      phase    <= 2'd0;
      mux_addr <= 3'b111;
      busy_q   <= 1'b1;
    end else begin
      busy_q <= adc_busy;
      if (!active) begin
        if (sample_go) begin
          active <= 1'b1;
          tick   <= '0;
        end
      end else if (tick == T_LAST) begin
        active <= 1'b0;
        tick   <= '0;
        phase  <= (phase == 2'd2) ? 2'd0 : phase + 2'd1;
      end else begin
        tick <= tick + 1'b1;
      end
      if (active && tick == T_MV) mux_addr <= {phase, 1'b0};
      if (active && tick == T_MI) mux_addr <= {phase, 1'b1};
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cst          <= C_IDLE;
      tcnt         <= '0;
      hi_q         <= '0;
      cur_q        <= 1'b0;
      res_valid    <= 1'b0;
      res_data     <= '0;
      res_phase    <= '0;
      res_current  <= 1'b0;
      conv_timeout <= 1'b0;
    end else begin
      res_valid    <= 1'b0;
      conv_timeout <= 1'b0;
      case (cst)
        C_IDLE: if (active && (tick == T_SV || tick == T_SI)) begin
          cst   <= C_CONV;
          tcnt  <= '0;
          cur_q <= (tick == T_SI);
        end
        C_CONV: begin
          if (eoc) begin
            cst <= C_RDHI;
          end else if (tcnt == T_TO) begin
            conv_timeout <= 1'b1;
            cst          <= C_IDLE;
          end else begin
            tcnt <= tcnt + 1'b1;
          end
        end
        C_RDHI: begin
          hi_q <= adc_data[3:0];
          cst  <= C_RDLO;
        end
        default: begin
          res_data    <= {hi_q, adc_data};
          res_phase   <= phase;
          res_current <= cur_q;
          res_valid   <= 1'b1;
          cst         <= C_IDLE;
        end
      endcase
    end
  end
endmodule

// File: rtl/sh_adc_seq_chk.sv
module sh_adc_seq_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [2:0]  hold,
  input logic [2:0]  mux_addr,
  input logic        adc_cs_n,
  input logic        adc_rd_n,
  input logic        adc_hbyte,
  input logic        res_valid,
  input logic        conv_timeout
);
  a_r2_one_hold: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hold));
  a_r4_conv_in_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !adc_cs_n |-> (hold != 3'b000));
  a_r3_mux_steady: assert property (@(posedge clk) disable iff (!rst_n)
    (!adc_cs_n && $past(!adc_cs_n)) |-> $stable(mux_addr));
  a_r5_hbyte_read: assert property (@(posedge clk) disable iff (!rst_n)
    adc_hbyte |-> (!adc_cs_n && !adc_rd_n));
  a_r5_lo_after_hi: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(adc_hbyte) |-> !adc_cs_n);
  a_r6_valid_after_low: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> $past(!adc_cs_n && !adc_hbyte));
  a_r6_valid_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |=> !res_valid);
  a_r7_timeout_excl: assert property (@(posedge clk) disable iff (!rst_n)
    conv_timeout |-> (!res_valid && adc_cs_n));
endmodule

bind sh_adc_sequencer sh_adc_seq_chk chk_i (
  .clk(clk), .rst_n(rst_n), .hold(hold), .mux_addr(mux_addr),
  .adc_cs_n(adc_cs_n), .adc_rd_n(adc_rd_n), .adc_hbyte(adc_hbyte),
  .res_valid(res_valid), .conv_timeout(conv_timeout)
);

// File: tb/sh_adc_sequencer_tb_top.sv
`timescale 1ns/1ps
module sh_adc_sequencer_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sample_go = 1'b0;
  logic adc_busy = 1'b1;
  logic [7:0] adc_data;
  logic [2:0] hold, mux_addr;
  logic adc_cs_n, adc_rd_n, adc_hbyte, res_valid, res_current, conv_timeout;
  logic [11:0] res_data;
  logic [1:0] res_phase;

  int errs = 0;
  int checks = 0;
  logic [7:0] salt = 8'h11;
  bit stuck_v = 0, stuck_i = 0, stuck_now = 0, in_conv = 0;
  int conv_len = 300;
  int cnt = 0;

  always #2.5 clk = ~clk;

  sh_adc_sequencer dut_i (
    .clk(clk), .rst_n(rst_n), .sample_go(sample_go), .adc_busy(adc_busy),
    .adc_data(adc_data), .hold(hold), .mux_addr(mux_addr), .adc_cs_n(adc_cs_n),
    .adc_rd_n(adc_rd_n), .adc_hbyte(adc_hbyte), .res_valid(res_valid),
    .res_data(res_data), .res_phase(res_phase), .res_current(res_current),
    .conv_timeout(conv_timeout)
  );

  function automatic logic [11:0] code_of(input logic [2:0] a);
    return {1'b1, a, salt ^ {5'd0, a}};
  endfunction

  logic [11:0] cur_code;
  assign cur_code = code_of(mux_addr);
  assign adc_data = adc_hbyte ? {4'h0, cur_code[11:8]} : cur_code[7:0];

  always @(negedge clk) begin
    if (!rst_n) begin
      adc_busy = 1'b1; in_conv = 0;
    end else if (!adc_cs_n && !in_conv) begin
      in_conv = 1; adc_busy = 1'b0; cnt = conv_len;
      stuck_now = mux_addr[0] ? stuck_i : stuck_v;
    end else if (in_conv && adc_cs_n) begin
      in_conv = 0; adc_busy = 1'b1;
    end else if (in_conv && !adc_busy && !stuck_now) begin
      if (cnt <= 1) adc_busy = 1'b1; else cnt = cnt - 1;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic test_reset();
    chk(hold == 3'b000, "R1 hold idle", hold, 0);
    chk(adc_cs_n && adc_rd_n && !adc_hbyte, "R1 adc controls idle",
        {adc_cs_n, adc_rd_n, adc_hbyte}, 6);
    chk(!res_valid && !conv_timeout, "R1 no strobe", {res_valid, conv_timeout}, 0);
    chk(mux_addr == 3'b111, "R1 mux parked", mux_addr, 7);
  endtask

  task automatic run_frame(input int ph, input bit sv, input bit si, input int clen,
                           input bit extra_go);
    int rise = -1, fall = -1, mv = -1, mi = -1, cs1 = -1, cs2 = -1, to_t = -1;
    int nres = 0, nto = 0, nhb = 0, badhold = 0;
    logic [2:0] pm, mvv = 0, miv = 0;
    logic pcs;
    stuck_v = sv; stuck_i = si; conv_len = clen; salt = salt + 8'h27;
    @(negedge clk); sample_go = 1'b1;
    @(negedge clk); sample_go = 1'b0;
    pm = mux_addr; pcs = adc_cs_n;
    for (int i = 0; i <= 3600; i++) begin
      sample_go = extra_go && (i == 1000);
      if (hold != 0 && hold != (3'b001 << ph)) badhold++;
      if (hold != 0 && rise < 0) rise = i;
      if (hold == 0 && rise >= 0 && fall < 0) fall = i;
      if (mux_addr != pm) begin
        if (mv < 0) begin mv = i; mvv = mux_addr; end
        else begin mi = i; miv = mux_addr; end
      end
      pm = mux_addr;
      if (!adc_cs_n && pcs) begin if (cs1 < 0) cs1 = i; else cs2 = i; end
      pcs = adc_cs_n;
      if (adc_hbyte) nhb++;
      if (conv_timeout) begin nto++; to_t = i; end
      if (res_valid) begin
        nres++;
        chk(res_data == code_of({ph[1:0], res_current}), "R5 result code",
            res_data, code_of({ph[1:0], res_current}));
        chk(res_phase == ph[1:0], "R6 phase tag", res_phase, ph);
        chk(res_current == (sv ? 1'b1 : (nres == 2)), "R6 current flag",
            res_current, (sv ? 1 : (nres == 2)));
      end
      @(negedge clk);
    end
    sample_go = 1'b0;
    chk(rise == 500, "R2 track length", rise, 500);
    chk(fall - rise == 3000, "R2 hold length", fall - rise, 3000);
    chk(badhold == 0, "R8 hold line of phase", badhold, 0);
    chk(mv == 550 && mvv == {ph[1:0], 1'b0}, "R3 voltage mux", mv, 550);
    chk(mi == 2050 && miv == {ph[1:0], 1'b1}, "R3 current mux", mi, 2050);
    chk(cs1 == 600, "R4 first start", cs1, 600);
    chk(cs2 == 2100, "R4 second start", cs2, 2100);
    chk(nres == 2 - int'(sv) - int'(si), "R6 strobe count", nres, 2 - int'(sv) - int'(si));
    chk(nhb == nres, "R5 one byte-select cycle per read", nhb, nres);
    chk(nto == int'(sv) + int'(si), "R7 timeout count", nto, int'(sv) + int'(si));
    if (sv) chk(to_t == 1350, "R7 timeout instant", to_t, 1350);
    if (si) chk(to_t == 2850, "R7 timeout instant", to_t, 2850);
    if (extra_go) chk(hold == 0 && adc_cs_n, "R9 no extra frame", hold, 0);
  endtask

  initial begin
    #2_000_000;
    errs++; checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    test_reset();
    rst_n = 1'b1;
    @(negedge clk);
    test_reset();
    run_frame(0, 0, 0, 300, 0);
    run_frame(1, 0, 0, 120, 1);
    run_frame(2, 1, 0, 300, 0);
    run_frame(0, 0, 1, 300, 0);
    run_frame(1, 0, 0, 700, 0);
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule